// File: doc/BRIEF.md
# Hot-Plug Slot Fault Latch

This block decides when a single hot-plug power slot is in fault, holds that decision, and drives the slot's rail enables and power-good indication from it. Its inputs are the main and auxiliary slot requests, per-rail undervoltage flags, fast and slow overcurrent trip flags, a slot over-temperature flag and a whole-chip over-temperature flag. Each of these is an already-digitised flag that may change at any time, so every one passes through a two-stage synchronizer before use. A diagnostic force-on input, gated by a software inhibit bit, can bypass all protection.

A fault is recognised only while at least one slot request is present. Once recognised it stays latched, all rails switch off, and it is released only when both requests are withdrawn. A slow overcurrent trip is not acted upon at once. It must either persist for a programmable number of clock cycles, or coincide with slot over-temperature. The filter count starts again from zero whenever the slow trip flag drops before it expires.

Top module: `slot_fault_latch`

## Requirements
- R1: With both the main request and the aux request low, `fault_o` stays 0 whatever the protection flags show.
- R2: While a request is active, an undervoltage flag on any of the three rails or a fast overcurrent flag sets `fault_o` to 1.
- R3: A slow overcurrent flag alone sets `fault_o` only after it has been high for `SLOW_FILT_CYCLES` consecutive synchronized cycles; if it drops earlier, the count restarts from zero.
- R4: A slow overcurrent flag together with the slot over-temperature flag sets `fault_o` without waiting for the filter.
- R5: The chip over-temperature flag alone sets `fault_o` while a request is active.
- R6: Once set, `fault_o` stays 1 after every trip flag has cleared and while either request remains; it returns to 0 only when both requests are low.
- R7: Rail enable bits 0 and 1 follow the main request and bit 2 follows the aux request; all three are 0 while `fault_o` is 1; `pwr_good_o` is 1 only when some rail is enabled, no fault is latched and no undervoltage flag is set.
- R8: While force-on is high and `force_inhibit_i` is 0, all three rail enables are 1 and `fault_o` and `pwr_good_o` are 0, regardless of requests and trip flags.
- R9: While `force_inhibit_i` is 1, force-on has no effect: outputs follow the requests and protection as if force-on were low.
- R10: While `rst_n` is low, `fault_o`, `pwr_good_o` and all rail enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| req_main_i | input | 1 | Main slot power request |
| req_aux_i | input | 1 | Auxiliary slot power request |
| uv_i | input | 3 | Undervoltage flags, one per rail |
| oc_fast_i | input | 1 | Fast overcurrent trip flag |
| oc_slow_i | input | 1 | Slow overcurrent trip flag |
| slot_hot_i | input | 1 | Slot over-temperature flag |
| chip_hot_i | input | 1 | Chip over-temperature flag |
| force_on_i | input | 1 | Diagnostic force-on request |
| force_inhibit_i | input | 1 | Control bit; 1 disables force-on |
| fault_o | output | 1 | Latched slot fault |
| pwr_good_o | output | 1 | Slot power good |
| rail_en_o | output | 3 | Rail enables (bits 0,1 main; bit 2 aux) |

## Verification
Each trip source is raised alone with a request held: one undervoltage rail, the fast trip, the slow trip with and without slot over-temperature, and the chip over-temperature flag. This shows that each path latches on its own and that the slow path alone is delayed. The slow trip is also held for just under the filter window, dropped, and raised again. A fault at that point would show that the counter failed to restart. Withdrawing one request at a time separates the latch-hold condition from the clear condition. Force-on is applied with live trip flags under both settings of the inhibit bit, which separates the override from ordinary protection.

// File: rtl/slot_fault_pkg.sv
package slot_fault_pkg;
    localparam int RAIL_CNT   = 3;
    localparam int MAIN_RAILS = 2;

    // Flag positions inside the synchronizer bank
    localparam int FL_REQ_MAIN = 0;
    localparam int FL_REQ_AUX  = 1;
    localparam int FL_UV_LO    = 2;
    localparam int FL_OC_FAST  = FL_UV_LO + RAIL_CNT;
    localparam int FL_OC_SLOW  = FL_OC_FAST + 1;
    localparam int FL_SLOT_HOT = FL_OC_SLOW + 1;
    localparam int FL_CHIP_HOT = FL_SLOT_HOT + 1;
    localparam int FL_FORCE    = FL_CHIP_HOT + 1;
    localparam int FLAG_CNT    = FL_FORCE + 1;

    typedef struct packed {
        logic                fault;
        logic                pwr_good;
        logic [RAIL_CNT-1:0] rails;
    } slot_state_t;
endpackage

// File: rtl/flag_sync_bank.sv
module flag_sync_bank #(
    parameter int WIDTH  = 10,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d;
        logic [STAGES-1:0] chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], raw_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/slow_oc_filter.sv
module slow_oc_filter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!trip_i)              cnt_d = '0;
        else if (cnt_q < LIMIT_V) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LIMIT_V);
endmodule

// File: rtl/slot_fault_core.sv
module slot_fault_core
    import slot_fault_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_main_s,
    input  logic                req_aux_s,
    input  logic [RAIL_CNT-1:0] uv_s,
    input  logic                oc_fast_s,
    input  logic                oc_slow_s,
    input  logic                slot_hot_s,
    input  logic                chip_hot_s,
    input  logic                force_on_s,
    input  logic                force_inhibit,
    input  logic                slow_expired,
    output slot_state_t         state_o
);
    slot_state_t st_d;
    slot_state_t st_q;

    logic force_act;
    logic req_any;
    logic uv_any;
    logic trip;

    always_comb begin
        force_act = force_on_s & ~force_inhibit;
        req_any   = req_main_s | req_aux_s;
        uv_any    = |uv_s;
        trip      = uv_any | oc_fast_s | chip_hot_s
                  | (oc_slow_s & (slow_expired | slot_hot_s));
        st_d      = st_q;
        if (force_act) begin
            st_d.fault    = 1'b0;
            st_d.pwr_good = 1'b0;
            st_d.rails    = '1;
        end else begin
            st_d.fault = req_any & (st_q.fault | trip);
            for (int i = 0; i < RAIL_CNT; i++) begin
                st_d.rails[i] = ((i < MAIN_RAILS) ? req_main_s : req_aux_s) & ~st_d.fault;
            end
            st_d.pwr_good = (|st_d.rails) & ~st_d.fault & ~uv_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/slot_fault_latch.sv
module slot_fault_latch
    import slot_fault_pkg::*;
#(
    parameter int SLOW_FILT_CYCLES = 1000,
    parameter int SYNC_STAGES      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_main_i,
    input  logic                req_aux_i,
    input  logic [RAIL_CNT-1:0] uv_i,
    input  logic                oc_fast_i,
    input  logic                oc_slow_i,
    input  logic                slot_hot_i,
    input  logic                chip_hot_i,
    input  logic                force_on_i,
    input  logic                force_inhibit_i,
    output logic                fault_o,
    output logic                pwr_good_o,
    output logic [RAIL_CNT-1:0] rail_en_o
);
    logic [FLAG_CNT-1:0] raw_flags;
    logic [FLAG_CNT-1:0] sync_flags;
    logic                slow_expired;
    slot_state_t         state;

    logic                req_any_s;
    logic                uv_any_s;
    logic [RAIL_CNT-1:0] uv_s;

    assign raw_flags = {force_on_i, chip_hot_i, slot_hot_i, oc_slow_i,
                        oc_fast_i, uv_i, req_aux_i, req_main_i};

    flag_sync_bank #(
        .WIDTH  (FLAG_CNT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_flags),
        .sync_o (sync_flags)
    );

    assign uv_s      = sync_flags[FL_UV_LO +: RAIL_CNT];
    assign uv_any_s  = |uv_s;
    assign req_any_s = sync_flags[FL_REQ_MAIN] | sync_flags[FL_REQ_AUX];

    slow_oc_filter #(
        .LIMIT     (SLOW_FILT_CYCLES)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_i    (sync_flags[FL_OC_SLOW]),
        .expired_o (slow_expired)
    );

    slot_fault_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_main_s    (sync_flags[FL_REQ_MAIN]),
        .req_aux_s     (sync_flags[FL_REQ_AUX]),
        .uv_s          (uv_s),
        .oc_fast_s     (sync_flags[FL_OC_FAST]),
        .oc_slow_s     (sync_flags[FL_OC_SLOW]),
        .slot_hot_s    (sync_flags[FL_SLOT_HOT]),
        .chip_hot_s    (sync_flags[FL_CHIP_HOT]),
        .force_on_s    (sync_flags[FL_FORCE]),
        .force_inhibit (force_inhibit_i),
        .slow_expired  (slow_expired),
        .state_o       (state)
    );

    assign fault_o    = state.fault;
    assign pwr_good_o = state.pwr_good;
    assign rail_en_o  = state.rails;
endmodule

// File: rtl/slot_fault_checker.sv
module slot_fault_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_any,
    input logic       uv_any,
    input logic       oc_fast,
    input logic       oc_slow,
    input logic       slot_hot,
    input logic       chip_hot,
    input logic       force_on,
    input logic       force_inhibit,
    input logic       fault_o,
    input logic       pwr_good_o,
    input logic [2:0] rail_en_o
);
    logic force_act;
    assign force_act = force_on & ~force_inhibit;

    a_r1_no_fault_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_any |=> !fault_o);

    a_r2_uv_fast_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (req_any && !force_act && (uv_any || oc_fast)) |=> fault_o);

    a_r4_slow_hot_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (req_any && !force_act && oc_slow && slot_hot) |=> fault_o);

    a_r5_chip_hot_trip: assert property (@(posedge clk) disable iff (!rst_n)
        (req_any && !force_act && chip_hot) |=> fault_o);

    a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && req_any && !force_act) |=> fault_o);

    a_r7_rails_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (rail_en_o == 3'b000));

    a_r7_pg_needs_rail: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good_o |-> (!fault_o && (rail_en_o != 3'b000)));

    a_r8_force_override: assert property (@(posedge clk) disable iff (!rst_n)
        force_act |=> (!fault_o && !pwr_good_o && rail_en_o == 3'b111));

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r10_reset_quiet: assert (!fault_o && !pwr_good_o && rail_en_o == 3'b000)
                else $error("outputs active during reset");
        end
    end
endmodule

bind slot_fault_latch slot_fault_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_any       (req_any_s),
    .uv_any        (uv_any_s),
    .oc_fast       (sync_flags[slot_fault_pkg::FL_OC_FAST]),
    .oc_slow       (sync_flags[slot_fault_pkg::FL_OC_SLOW]),
    .slot_hot      (sync_flags[slot_fault_pkg::FL_SLOT_HOT]),
    .chip_hot      (sync_flags[slot_fault_pkg::FL_CHIP_HOT]),
    .force_on      (sync_flags[slot_fault_pkg::FL_FORCE]),
    .force_inhibit (force_inhibit_i),
    .fault_o       (fault_o),
    .pwr_good_o    (pwr_good_o),
    .rail_en_o     (rail_en_o)
);

// File: tb/sim_slot_fault_latch.sv
module sim_slot_fault_latch;
    localparam int FILT = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_main = 1'b0, req_aux = 1'b0;
    logic [2:0] uv = 3'b000;
    logic       oc_fast = 1'b0, oc_slow = 1'b0, slot_hot = 1'b0, chip_hot = 1'b0;
    logic       force_on = 1'b0, inhibit = 1'b0;
    logic       fault, pg;
    logic [2:0] rails;

    always #2 clk = ~clk;

    slot_fault_latch #(.SLOW_FILT_CYCLES(FILT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_main_i(req_main), .req_aux_i(req_aux),
        .uv_i(uv), .oc_fast_i(oc_fast), .oc_slow_i(oc_slow), .slot_hot_i(slot_hot),
        .chip_hot_i(chip_hot), .force_on_i(force_on), .force_inhibit_i(inhibit),
        .fault_o(fault), .pwr_good_o(pg), .rail_en_o(rails)
    );

    typedef struct {
        logic       f;
        logic       p;
        logic [2:0] r;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    // Monitor: pops expectations and compares away from the rising edge
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (fault !== e.f || pg !== e.p || rails !== e.r) begin
                fails++;
                $display("FAIL %s: got fault=%b pg=%b rails=%b expected fault=%b pg=%b rails=%b",
                         e.tag, fault, pg, rails, e.f, e.p, e.r);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic f, input logic p, input logic [2:0] r, input string tag);
        exp_t e;
        e.f = f; e.p = p; e.r = r; e.tag = tag;
        sb.push_back(e);
        wait_cyc(2);
    endtask

    task automatic settle_expect(input logic f, input logic p, input logic [2:0] r, input string tag);
        wait_cyc(5);
        expect_out(f, p, r, tag);
    endtask

    initial begin
        wait_cyc(3);
        expect_out(1'b0, 1'b0, 3'b000, "R10 outputs quiet in reset");
        rst_n = 1'b1;
        settle_expect(1'b0, 1'b0, 3'b000, "R10 idle after reset");

        req_main = 1'b1;
        settle_expect(1'b0, 1'b1, 3'b011, "R7 main rails on");
        req_aux = 1'b1;
        settle_expect(1'b0, 1'b1, 3'b111, "R7 all rails on");

        uv[1] = 1'b1;
        settle_expect(1'b1, 1'b0, 3'b000, "R2 uv rail1 fault");
        uv[1] = 1'b0;
        settle_expect(1'b1, 1'b0, 3'b000, "R6 held after uv clears");
        req_main = 1'b0;
        settle_expect(1'b1, 1'b0, 3'b000, "R6 held with aux only");
        req_aux = 1'b0;
        settle_expect(1'b0, 1'b0, 3'b000, "R6 cleared by both low");

        uv = 3'b101; oc_fast = 1'b1; chip_hot = 1'b1;
        settle_expect(1'b0, 1'b0, 3'b000, "R1 no fault without request");
        uv = 3'b000; chip_hot = 1'b0;

        req_aux = 1'b1;
        settle_expect(1'b1, 1'b0, 3'b000, "R2 fast trip on aux");
        oc_fast = 1'b0; req_aux = 1'b0;
        settle_expect(1'b0, 1'b0, 3'b000, "R6 clear after fast trip");

        req_main = 1'b1;
        wait_cyc(5);
        oc_slow = 1'b1;
        wait_cyc(10);
        expect_out(1'b0, 1'b1, 3'b011, "R3 slow trip below window");
        oc_slow = 1'b0;
        wait_cyc(4);
        oc_slow = 1'b1;
        wait_cyc(12);
        expect_out(1'b0, 1'b1, 3'b011, "R3 filter restarted after drop");
        wait_cyc(15);
        expect_out(1'b1, 1'b0, 3'b000, "R3 slow trip after window");
        oc_slow = 1'b0; req_main = 1'b0;
        settle_expect(1'b0, 1'b0, 3'b000, "R6 clear after slow trip");

        req_main = 1'b1; slot_hot = 1'b1;
        settle_expect(1'b0, 1'b1, 3'b011, "R4 slot hot alone no fault");
        oc_slow = 1'b1;
        settle_expect(1'b1, 1'b0, 3'b000, "R4 slow plus slot hot immediate");
        oc_slow = 1'b0; slot_hot = 1'b0; req_main = 1'b0;
        wait_cyc(5);

        req_aux = 1'b1;
        settle_expect(1'b0, 1'b1, 3'b100, "R7 aux rail only");
        chip_hot = 1'b1;
        settle_expect(1'b1, 1'b0, 3'b000, "R5 chip hot fault");
        chip_hot = 1'b0; req_aux = 1'b0;
        settle_expect(1'b0, 1'b0, 3'b000, "R5 cleared");

        req_main = 1'b1; uv = 3'b001; chip_hot = 1'b1; force_on = 1'b1;
        settle_expect(1'b0, 1'b0, 3'b111, "R8 force overrides protection");
        req_main = 1'b0;
        settle_expect(1'b0, 1'b0, 3'b111, "R8 force without request");
        req_main = 1'b1; force_on = 1'b0;
        settle_expect(1'b1, 1'b0, 3'b000, "R8 protection back after force");
        uv = 3'b000; chip_hot = 1'b0; req_main = 1'b0;
        wait_cyc(5);

        inhibit = 1'b1; force_on = 1'b1;
        settle_expect(1'b0, 1'b0, 3'b000, "R9 inhibited force no rails");
        req_main = 1'b1;
        settle_expect(1'b0, 1'b1, 3'b011, "R9 inhibited force normal rails");
        uv = 3'b100;
        settle_expect(1'b1, 1'b0, 3'b000, "R9 protection active when inhibited");
        uv = 3'b000; req_main = 1'b0; force_on = 1'b0;
        settle_expect(1'b0, 1'b0, 3'b000, "R9 cleared");

        wait_cyc(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule